// File: doc/BRIEF.md
# Serial Converter Port Sequencer

This block is the digital front of a 10-bit successive-approximation converter that a host reaches over a four-wire serial port. The wires are an active-low select, a serial clock, a serial address line and a three-state result line. All port inputs are brought into one system clock domain and their edges are detected there. The three-state result line is modelled as a data bit plus an output enable.

During each transfer the host clocks in a 4-bit channel code, most significant bit first. The code picks one of 14 multiplexer inputs: codes 0 to 10 are external channels and codes 11 to 13 are internal self-test inputs. While the code goes in, the host reads the previous 10-bit result out. The block opens a sampling window, closes it at the hold point, and hands the conversion to an engine behind it with a one-cycle start pulse. A ready flag falls at that hand-off. It rises again when the engine reports a new result.

While select stays low between transfers, the next transfer starts by itself. It starts either when the conversion completes or on the last allowed falling clock edge, depending on whether the conversion finished before or after the host's transfer.

Top module: `adc_sport_ctrl`

## Requirements
- R1: While selected, the first four rising serial-clock edges shift the address line into a 4-bit code, most significant bit first. `chan_sel_o` takes the code after the fourth edge. The address line has no effect on it for the rest of that transfer.
- R2: `chan_sel_o` always carries the raw 4-bit code. `chan_bad_o` is high exactly when that code is 14 or 15.
- R3: `sample_en_o` rises after the fourth falling serial-clock edge and falls after the tenth. It is low after reset and while deselected.
- R4: After the tenth falling edge, `conv_start_o` gives exactly one system-clock pulse and `ready_o` drops low.
- R5: `ready_o` is high after reset. A `conv_done_i` pulse drives it high again and stores `conv_result_i` as the new previous result.
- R6: When select falls, `dout_oe_o` goes high and `dout_o` shows bit 9 of the previous result.
- R7: The k-th falling edge of a transfer (k = 1 to 9) puts bit 9-k of the previous result on `dout_o`. Bit 0 appears after the ninth edge.
- R8: From the tenth falling edge up to the sixteenth, `dout_o` is 0.
- R9: While select is high, `dout_oe_o` is 0 and the serial clock and address line are ignored. Every select fall restarts the edge counts from zero.
- R10: Select is held low. The conversion completes either with fewer than 11 rising edges seen, or after all 16 falling edges. A new transfer then begins at once, and `dout_o` shows bit 9 of the new result.
- R11: Select is held low. The conversion completes after the 11th rising edge but before the 16th falling edge. The new transfer then begins at the 16th falling edge, and `dout_o` shows bit 9 of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Port select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial channel address from host |
| dout_o | output | 1 | Serial result bit |
| dout_oe_o | output | 1 | Output enable for the result line |
| ready_o | output | 1 | High when a finished result is waiting |
| chan_sel_o | output | 4 | Multiplexer select code |
| chan_bad_o | output | 1 | Select code is outside 0..13 |
| sample_en_o | output | 1 | Sampling window open |
| conv_start_o | output | 1 | One-cycle start pulse to the converter engine |
| conv_done_i | input | 1 | One-cycle pulse from the engine when a result is valid |
| conv_result_i | input | 10 | Result word from the engine |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 4-bit code, 14 valid inputs, at most 16 edges per transfer and two synchronizer stages. The serial clock half period is eight system clocks. The placeholder engine is run with a latency of either 40 or 300 system clocks. The short latency lets a result finish in the middle of a 16-edge transfer, which reaches the deferred restart at the last edge. The long latency makes results finish after 16-edge transfers, which reaches the immediate restart on completion. Random codes include the two out-of-range values, and random lengths cover every transfer length from 10 to 16 edges.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

  // Port events seen in the system clock domain.
  typedef struct packed {
    logic cs_act;   // select is low (synchronized)
    logic cs_fall;  // select just went low
    logic rise;     // serial clock rising edge while selected
    logic fall;     // serial clock falling edge while selected
  } io_ev_t;

endpackage

// File: rtl/adc_sport_sync.sv
module adc_sport_sync
  import adc_sport_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cs_n_i,
  input  logic   sclk_i,
  input  logic   sdi_i,
  output io_ev_t ev_o,
  output logic   sdi_s_o
);

  localparam int W = 3;

  logic [W*STAGES-1:0] chain_q;
  logic [W-1:0]        raw, fin;
  logic                cs_prev_q, ck_prev_q;

  assign raw = {cs_n_i, sclk_i, sdi_i};

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 3'b100;
        else     chain_q <= raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{3'b100}};
        else     chain_q <= {chain_q[W*(STAGES-1)-1:0], raw};
      end
    end
  endgenerate

  assign fin = chain_q[W*STAGES-1 -: W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q <= 1'b1;
      ck_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= fin[2];
      ck_prev_q <= fin[1];
    end
  end

  assign ev_o.cs_act  = ~fin[2];
  assign ev_o.cs_fall = cs_prev_q & ~fin[2];
  assign ev_o.rise    = ~fin[2] & fin[1] & ~ck_prev_q;
  assign ev_o.fall    = ~fin[2] & ~fin[1] & ck_prev_q;
  assign sdi_s_o      = fin[0];

endmodule

// File: rtl/adc_sport_seq.sv
module adc_sport_seq
  import adc_sport_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_CH    = 14,
  parameter int HOLD_EDGE = 10,
  parameter int MAX_EDGES = 16,
  parameter int CNT_W     = $clog2(MAX_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  io_ev_t            ev_i,
  input  logic              sdi_s_i,
  input  logic              conv_done_i,
  output logic [ADDR_W-1:0] chan_o,
  output logic              bad_o,
  output logic              samp_o,
  output logic              start_o,
  output logic              ready_o,
  output logic              restart_o,
  output logic [CNT_W-1:0]  fall_idx_o
);

  localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_HOLD = CNT_W'(HOLD_EDGE);
  localparam logic [CNT_W-1:0] C_SLOW = CNT_W'(HOLD_EDGE + 1);
  localparam logic [CNT_W-1:0] C_MAX  = CNT_W'(MAX_EDGES);
  localparam logic [ADDR_W-1:0] C_TOP = ADDR_W'(NUM_CH - 1);

  logic [CNT_W-1:0]  rise_q, fall_q;
  logic [ADDR_W-1:0] addr_sh_q, chan_q, nxt_addr;
  logic              bad_q, samp_q, start_q, ready_q, pend_q;
  logic              done_rise, hold_done, fast_done, slow_arm, last_fall;
  logic              at_samp_fall, at_hold_fall, restart;

  assign nxt_addr     = {addr_sh_q[ADDR_W-2:0], sdi_s_i};
  assign at_samp_fall = ev_i.fall & (fall_q == C_ADDR - 1'b1);
  assign at_hold_fall = ev_i.fall & (fall_q == C_HOLD - 1'b1);

  // Restart decision when the converter finishes with select held low.
  assign done_rise = conv_done_i & ~ready_q;
  assign hold_done = fall_q >= C_HOLD;
  assign fast_done = ev_i.cs_act & done_rise & hold_done &
                     ((fall_q == C_MAX) | (rise_q < C_SLOW));
  assign slow_arm  = ev_i.cs_act & done_rise & hold_done &
                     (fall_q != C_MAX) & (rise_q >= C_SLOW);
  assign last_fall = ev_i.fall & (pend_q | slow_arm) & (fall_q == C_MAX - 1'b1);
  assign restart   = fast_done | last_fall;

  always_ff @(posedge clk) begin
    if (rst || ev_i.cs_fall || restart) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (ev_i.rise && rise_q != C_MAX) rise_q <= rise_q + 1'b1;
      if (ev_i.fall && fall_q != C_MAX) fall_q <= fall_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ev_i.cs_fall || restart || !ev_i.cs_act) pend_q <= 1'b0;
    else if (slow_arm)                                   pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sh_q <= '0;
      chan_q    <= '0;
      bad_q     <= 1'b0;
    end else if (ev_i.rise && rise_q < C_ADDR) begin
      addr_sh_q <= nxt_addr;
      if (rise_q == C_ADDR - 1'b1) begin
        chan_q <= nxt_addr;
        bad_q  <= nxt_addr > C_TOP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ev_i.cs_act) samp_q <= 1'b0;
    else if (at_samp_fall)   samp_q <= 1'b1;
    else if (at_hold_fall)   samp_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      start_q <= at_hold_fall;
      if (at_hold_fall)     ready_q <= 1'b0;
      else if (conv_done_i) ready_q <= 1'b1;
    end
  end

  assign chan_o     = chan_q;
  assign bad_o      = bad_q;
  assign samp_o     = samp_q;
  assign start_o    = start_q;
  assign ready_o    = ready_q;
  assign restart_o  = restart;
  assign fall_idx_o = fall_q;

  // R4: the start strobe lasts a single system cycle.
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R5: ready only rises in answer to the engine's done pulse.
  p_ready_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(conv_done_i));

  // R3: while selected, the sampling window closes exactly as conversion starts.
  p_sample_close_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(samp_q) && ev_i.cs_act && $past(ev_i.cs_act)) |-> start_q);

  // R1: rising edges past the address field leave the channel code alone.
  p_chan_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (ev_i.rise && rise_q >= C_ADDR) |=> $stable(chan_q));

endmodule

// File: rtl/adc_sport_shift.sv
module adc_sport_shift #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] res_i,
  output logic             dout_o,
  output logic             oe_o
);

  logic [RES_W-1:0] res_q, sh_q, ld_val;
  logic             oe_q;

  // A restart on completion must see the word arriving in the same cycle.
  assign ld_val = conv_done_i ? res_i : res_q;

  always_ff @(posedge clk) begin
    if (rst)              res_q <= '0;
    else if (conv_done_i) res_q <= res_i;
  end

  // Zero fill: after RES_W shifts the line carries only zeros.
  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= ld_val;
    else if (shift_i) sh_q <= {sh_q[RES_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= cs_act_i;
  end

  assign dout_o = sh_q[RES_W-1];
  assign oe_o   = oe_q;

  // R9: a deselected port releases the result line on the next cycle.
  p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_act_i |=> !oe_q);

endmodule

// File: rtl/adc_sport_ctrl.sv
module adc_sport_ctrl
  import adc_sport_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int NUM_CH      = 14,
  parameter int MAX_EDGES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] chan_sel_o,
  output logic              chan_bad_o,
  output logic              sample_en_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i
);

  localparam int CNT_W = $clog2(MAX_EDGES + 1);

  io_ev_t           ev;
  logic             sdi_s, restart;
  logic [CNT_W-1:0] fall_idx;

  adc_sport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .cs_n_i  (cs_n_i),
    .sclk_i  (sclk_i),
    .sdi_i   (sdi_i),
    .ev_o    (ev),
    .sdi_s_o (sdi_s)
  );

  adc_sport_seq #(
    .ADDR_W    (ADDR_W),
    .NUM_CH    (NUM_CH),
    .HOLD_EDGE (RES_W),
    .MAX_EDGES (MAX_EDGES),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ev_i        (ev),
    .sdi_s_i     (sdi_s),
    .conv_done_i (conv_done_i),
    .chan_o      (chan_sel_o),
    .bad_o       (chan_bad_o),
    .samp_o      (sample_en_o),
    .start_o     (conv_start_o),
    .ready_o     (ready_o),
    .restart_o   (restart),
    .fall_idx_o  (fall_idx)
  );

  adc_sport_shift #(.RES_W(RES_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .cs_act_i    (ev.cs_act),
    .load_i      (ev.cs_fall | restart),
    .shift_i     (ev.fall),
    .conv_done_i (conv_done_i),
    .res_i       (conv_result_i),
    .dout_o      (dout_o),
    .oe_o        (dout_oe_o)
  );

  // R8: once the hold edge is counted, the result line stays low.
  p_tail_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (fall_idx >= CNT_W'(RES_W)) |-> !dout_o);

endmodule

// File: tb/tb_adc_sport_ctrl.sv
module tb_adc_sport_ctrl;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       addr = 1'b0;
  logic       conv_done;
  logic [9:0] conv_res;
  logic       dout, dout_oe, ready, chan_bad, sample_en, conv_start;
  logic [3:0] chan_sel;

  int         lat = 40;
  int         eng_cnt;
  int         nconv;
  int         nstart;
  logic [9:0] last_res;
  logic [3:0] cur_addr = 4'd0;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  adc_sport_ctrl dut (
    .clk           (clk),
    .rst           (rst),
    .cs_n_i        (cs_n),
    .sclk_i        (sclk),
    .sdi_i         (addr),
    .dout_o        (dout),
    .dout_oe_o     (dout_oe),
    .ready_o       (ready),
    .chan_sel_o    (chan_sel),
    .chan_bad_o    (chan_bad),
    .sample_en_o   (sample_en),
    .conv_start_o  (conv_start),
    .conv_done_i   (conv_done),
    .conv_result_i (conv_res)
  );

  function automatic logic [9:0] mk_res(input logic [3:0] a, input int n);
    return {a, 6'((n * 13 + 5) % 64)};
  endfunction

  // Placeholder converter engine with programmable latency.
  always @(posedge clk) begin
    if (rst) begin
      eng_cnt   <= 0;
      conv_done <= 1'b0;
      conv_res  <= '0;
      last_res  <= '0;
      nconv     <= 0;
      nstart    <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        eng_cnt <= lat;
        nstart  <= nstart + 1;
      end else if (eng_cnt > 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) begin
          conv_done <= 1'b1;
          conv_res  <= mk_res(cur_addr, nconv);
          last_res  <= mk_res(cur_addr, nconv);
          nconv     <= nconv + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int k = 0;
    while (ready !== 1'b1 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk("R5 ready returns after done", 32'(ready), 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [3:0] a, input int n, input bit toggle, input bit slow_end);
    logic [9:0] snap;
    int         s0;
    logic       expb;
    cur_addr = a;
    snap     = last_res;
    if (toggle) begin
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk("R6 enable on select", 32'(dout_oe), 1);
    chk("R6 msb of previous result", 32'(dout), 32'(snap[9]));
    s0 = nstart;
    for (int i = 1; i <= n; i++) begin
      addr = (i <= 4) ? a[4-i] : 1'($urandom_range(0, 1));
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i == 4) begin
        chk("R1 code captured msb first", 32'(chan_sel), 32'(a));
        chk("R2 out-of-range flag", 32'(chan_bad), 32'(a > 4'd13));
      end
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      expb = (i < 10) ? snap[9-i] : 1'b0;
      if (slow_end && i == n) begin
        expb = last_res[9];
        chk("R11 new msb at last edge", 32'(dout), 32'(expb));
      end else if (i < 10) begin
        chk("R7 serial result bit", 32'(dout), 32'(expb));
      end else begin
        chk("R8 zero tail", 32'(dout), 32'(expb));
      end
      if (i == 4 || i == 9) chk("R3 window open", 32'(sample_en), 1);
      if (i == 10) begin
        chk("R3 window closed at hold", 32'(sample_en), 0);
        chk("R4 ready low after hold", 32'(ready), 0);
        chk("R4 single start pulse", 32'(nstart), 32'(s0 + 1));
      end
    end
    if (n > 4) chk("R1 later address bits ignored", 32'(chan_sel), 32'(a));
    if (toggle) begin
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 line released when deselected", 32'(dout_oe), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    chk("R9 reset: line released", 32'(dout_oe), 0);
    chk("R5 reset: ready high", 32'(ready), 1);
    chk("R3 reset: window closed", 32'(sample_en), 0);
    chk("R4 reset: no start", 32'(conv_start), 0);

    // R9: clocks while deselected are ignored.
    for (int i = 0; i < 6; i++) begin
      addr = 1'($urandom_range(0, 1));
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    chk("R9 no start while deselected", 32'(nstart), 0);
    chk("R9 window closed while deselected", 32'(sample_en), 0);

    // Select toggled, 10-edge transfers, directed codes.
    lat = 40;
    xfer(4'd5, 10, 1'b1, 1'b0);  wait_ready();
    xfer(4'd14, 10, 1'b1, 1'b0); wait_ready();
    xfer(4'd15, 10, 1'b1, 1'b0); wait_ready();
    xfer(4'd13, 10, 1'b1, 1'b0); wait_ready();

    // Select toggled, random codes and lengths, conversion ends after deselect.
    lat = 300;
    for (int k = 0; k < 7; k++) begin
      xfer(4'($urandom_range(0, 15)), 10 + (k % 7), 1'b1, 1'b0);
      wait_ready();
    end

    // Select held low, 10-edge transfers: restart on completion.
    lat = 40;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      xfer(4'($urandom_range(0, 15)), 10, 1'b0, 1'b0);
      wait_ready();
      chk("R10 new msb on completion", 32'(dout), 32'(last_res[9]));
      chk("R10 line stays enabled", 32'(dout_oe), 1);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);

    // Select held low, 16 edges, conversion ends after the transfer.
    lat = 300;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      xfer(4'($urandom_range(0, 15)), 16, 1'b0, 1'b0);
      wait_ready();
      chk("R10 new msb after full transfer", 32'(dout), 32'(last_res[9]));
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);

    // Select held low, 16 edges, conversion ends inside the transfer.
    lat = 40;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      xfer(4'($urandom_range(0, 15)), 16, 1'b0, 1'b1);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 released at end", 32'(dout_oe), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule